// File: doc/BRIEF.md
# External Interrupt Input Detector

This block watches a single external interrupt pin and turns activity on it into a request flag for an interrupt controller. A two-flop synchronizer first brings the asynchronous pin into the clock domain. A divide-by-12 counter produces a machine-cycle strobe, and the synchronized pin is looked at only on that strobe. Any pin activity that starts and ends between two strobes is never seen.

A mode input selects how the flag behaves. In level mode, the flag is refreshed at every strobe to show whether the pin was low, and the controller's vectoring acknowledge has no effect on it. In falling-edge mode, the flag is set when one strobe sample reads high and the next reads low. It then holds until the acknowledge clears it. Software can overwrite the flag through a write strobe, and the write takes effect on the clock edge where it is presented.

Top module: `ext_irq_detect`

## Requirements
- R1: `mc_tick_o` is high for exactly one clock in every 12. After reset is released, its first high cycle is the 12th clock.
- R2: The pin is sampled only when `mc_tick_o` is high. A low pulse that begins and ends between two strobes leaves `req_o` unchanged in both modes.
- R3: With `edge_mode_i` = 0 (level mode), `req_o` becomes 1 on each strobe whose sample is low and 0 on each strobe whose sample is high.
- R4: In level mode, `vec_ack_i` does not change `req_o`. A pin still held low keeps the flag at 1.
- R5: With `edge_mode_i` = 1 (falling-edge mode), `req_o` is set on a strobe whose sample is low when the previous strobe's sample was high. With no edge, acknowledge or write, it holds its value.
- R6: In falling-edge mode, a pulse on `vec_ack_i` clears `req_o` on that clock edge.
- R7: In falling-edge mode, when a detected falling edge and `vec_ack_i` occur on the same clock edge, `req_o` ends up 1.
- R8: A pulse on `sw_we_i` loads `sw_wdata_i` into `req_o` on that clock edge. The write takes priority over a detected edge, a level update and an acknowledge. In level mode, the next strobe overwrites the written value.
- R9: Reset (`rst_ni` low) clears `req_o` at once and restarts the strobe counter. It also sets the previous-sample state to high, so a pin found low at the first strobe in falling-edge mode sets `req_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously by its source |
| pin_i | input | 1 | Raw asynchronous interrupt pin, active low |
| edge_mode_i | input | 1 | 0 = level mode, 1 = falling-edge mode |
| vec_ack_i | input | 1 | One-clock pulse from the controller when the service routine is vectored to |
| sw_we_i | input | 1 | Software write strobe for the flag |
| sw_wdata_i | input | 1 | Value written to the flag when `sw_we_i` is high |
| mc_tick_o | output | 1 | Machine-cycle strobe, high one clock in 12 |
| req_o | output | 1 | Interrupt request flag |

## Verification
The hardest cases to reach are coincidences on the strobe clock itself. One is an acknowledge landing on the very edge where a falling edge is detected. Another is a software write meeting a falling edge on that same edge. A third is a short pin pulse that falls entirely between strobes. Each stimulus step in the bench spans exactly one machine cycle, aligned to the strobe from reset release. Every step can place its acknowledge or write pulse either on the first clock of the machine cycle or on the strobe clock. The flag is checked both mid-cycle and just after the strobe, so the effect of the pulse and the effect of the sample are seen separately.

// File: rtl/irq_det_pkg.sv
package irq_det_pkg;

  typedef enum logic {
    TRIG_LEVEL = 1'b0,
    TRIG_FALL  = 1'b1
  } trig_mode_e;

  localparam int unsigned MC_DIV_DEFAULT    = 12;
  localparam int unsigned SYNC_LEN_DEFAULT  = 2;

endpackage

// File: rtl/irq_mc_divider.sv
module irq_mc_divider #(
  parameter int unsigned DIV = 12
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);

  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign tick_o = (cnt_q == LAST);

  always_comb begin
    if (tick_o) cnt_d = '0;
    else        cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  // R1: strobe never lasts two clocks, counter stays in range
  p_tick_single_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
  p_cnt_range_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);

endmodule

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic sync_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  assign chain_d[0] = async_i;

  genvar g;
  generate
    for (g = 1; g < STAGES; g++) begin : g_stage
      assign chain_d[g] = chain_q[g-1];
    end
  endgenerate

  // idle level of the pin is high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '1;
    else         chain_q <= chain_d;
  end

  assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/irq_sample_edge.sv
module irq_sample_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic pin_i,
  output logic fall_o
);

  logic last_q, last_d;

  always_comb begin
    if (tick_i) last_d = pin_i;
    else        last_d = last_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) last_q <= 1'b1;
    else         last_q <= last_d;
  end

  assign fall_o = tick_i & last_q & ~pin_i;

  // R2: the stored sample only moves on a strobe
  p_sample_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(last_q));

endmodule

// File: rtl/ext_irq_detect.sv
module ext_irq_detect
  import irq_det_pkg::*;
#(
  parameter int unsigned MC_DIV   = MC_DIV_DEFAULT,
  parameter int unsigned SYNC_LEN = SYNC_LEN_DEFAULT
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic edge_mode_i,
  input  logic vec_ack_i,
  input  logic sw_we_i,
  input  logic sw_wdata_i,
  output logic mc_tick_o,
  output logic req_o
);

  trig_mode_e mode;
  logic       tick;
  logic       pin_s;
  logic       fall;
  logic       flag_q, flag_d;

  assign mode = trig_mode_e'(edge_mode_i);

  irq_mc_divider #(.DIV(MC_DIV)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick)
  );

  irq_pin_sync #(.STAGES(SYNC_LEN)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (pin_i),
    .sync_o  (pin_s)
  );

  irq_sample_edge u_smp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick),
    .pin_i  (pin_s),
    .fall_o (fall)
  );

  // flag next state: write > mode-specific update
  always_comb begin
    flag_d = flag_q;
    if (sw_we_i) begin
      flag_d = sw_wdata_i;
    end else if (mode == TRIG_LEVEL) begin
      if (tick) flag_d = ~pin_s;
    end else begin
      if (fall)           flag_d = 1'b1;
      else if (vec_ack_i) flag_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else         flag_q <= flag_d;
  end

  assign req_o     = flag_q;
  assign mc_tick_o = tick;

  p_level_follow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && !edge_mode_i && !sw_we_i) |=> (req_o == !$past(pin_s)));

  p_level_ack_ignored_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!edge_mode_i && vec_ack_i && !tick && !sw_we_i) |=> $stable(req_o));

  p_edge_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_mode_i && !fall && !vec_ack_i && !sw_we_i) |=> $stable(req_o));

  p_ack_clears_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_mode_i && vec_ack_i && !fall && !sw_we_i) |=> !req_o);

  p_fall_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_mode_i && fall && !sw_we_i) |=> req_o);

  p_sw_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_we_i |=> (req_o == $past(sw_wdata_i)));

  p_no_tick_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick && !sw_we_i && !(edge_mode_i && vec_ack_i)) |=> $stable(req_o));

endmodule

// File: tb/sim_ext_irq_detect.sv
`timescale 1ns/1ps
module sim_ext_irq_detect;

  logic clk = 1'b0;
  logic rst_ni;
  logic pin_i, edge_mode_i, vec_ack_i, sw_we_i, sw_wdata_i;
  logic mc_tick_o, req_o;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk; // 50 MHz

  ext_irq_detect u0 (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .pin_i       (pin_i),
    .edge_mode_i (edge_mode_i),
    .vec_ack_i   (vec_ack_i),
    .sw_we_i     (sw_we_i),
    .sw_wdata_i  (sw_wdata_i),
    .mc_tick_o   (mc_tick_o),
    .req_o       (req_o)
  );

  // {mode, pin, we, wdata, ack, late, exp_mid, exp_end}
  localparam logic [7:0] VEC [0:16] = '{
    8'b1100_0000, 8'b1000_0001, 8'b1000_0011, 8'b1000_1000,
    8'b1100_0000, 8'b1000_1101, 8'b1110_0000, 8'b1111_0011,
    8'b1010_0110, 8'b0000_0001, 8'b0000_1011, 8'b0100_0010,
    8'b0111_0010, 8'b0000_0001, 8'b1100_0011, 8'b1000_1001,
    8'b1100_1000
  };

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic pulses(input logic we, input logic wd, input logic ack);
    sw_we_i    = we;
    sw_wdata_i = wd;
    vec_ack_i  = ack;
  endtask

  // one machine cycle, starting at the negedge after a strobe edge
  task automatic mc_step(input logic [7:0] v, input string tag);
    edge_mode_i = v[7];
    pin_i       = v[6];
    if (!v[2]) pulses(v[5], v[4], v[3]);
    @(negedge clk);
    pulses(1'b0, 1'b0, 1'b0);
    chk({tag, " mid"}, req_o, v[1]);
    chk("R1 no strobe", mc_tick_o, 1'b0);
    repeat (10) @(negedge clk);
    chk("R1 strobe", mc_tick_o, 1'b1);
    if (v[2]) pulses(v[5], v[4], v[3]);
    @(negedge clk);
    pulses(1'b0, 1'b0, 1'b0);
    chk({tag, " end"}, req_o, v[0]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_ni = 1'b0;
    pin_i = 1'b1; edge_mode_i = 1'b1;
    pulses(1'b0, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    chk("R9 reset flag", req_o, 1'b0);
    rst_ni = 1'b1;

    for (int i = 0; i < 17; i++) begin
      string tag;
      logic [7:0] v;
      v = VEC[i];
      if (v[5])               tag = "R8";
      else if (!v[7] && v[3]) tag = "R4";
      else if (!v[7])         tag = "R3";
      else if (v[3] && v[2])  tag = "R7";
      else if (v[3])          tag = "R6";
      else                    tag = "R5";
      mc_step(v, tag);
    end

    // R2: short low pulse between strobes, both modes
    for (int m = 1; m >= 0; m--) begin
      edge_mode_i = logic'(m);
      repeat (3) @(negedge clk);
      pin_i = 1'b0;
      repeat (3) @(negedge clk);
      pin_i = 1'b1;
      repeat (5) @(negedge clk);
      chk("R1 strobe", mc_tick_o, 1'b1);
      @(negedge clk);
      chk("R2 glitch ignored", req_o, 1'b0);
    end

    // set flag in level mode, then reset mid-cycle
    mc_step(8'b0000_0001, "R3");
    repeat (5) @(negedge clk);
    rst_ni = 1'b0;
    #1;
    chk("R9 async clear", req_o, 1'b0);
    edge_mode_i = 1'b1;
    pin_i = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    repeat (11) @(negedge clk);
    chk("R1 first strobe", mc_tick_o, 1'b1);
    chk("R9 before strobe", req_o, 1'b0);
    @(negedge clk);
    chk("R9 prev high", req_o, 1'b1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule